// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

The block joins two 18-bit ports, A and B. Each direction has its own store and its own controls. Each store runs in one of three modes: transparent, held, or loaded on a falling clock edge. In transparent mode the output follows the input combinationally. In held mode the stored word stays put while the latch enable is low and the clock does not fall. In loaded mode a falling clock edge takes in the input word while the latch enable is low. The A-to-B output enable is active high and the B-to-A output enable is active low. Each port's driver is brought out as a data word plus a drive-enable bit, so that an outer pad ring or a bench can resolve the shared wires.

Every input port has a behavioural keeper beside it, which acts as bus hold. The source side says by a per-port drive flag whether it is actually driving the port. When nobody drives it, the store sees the last word that was driven and never a floating value. A power-up reset input holds both ports undriven, whatever the enables say, and clears both stores and both keepers to zero.

Top module: `ubt_xcvr`

## Requirements
- R1: Both ports are W = 18 bits wide, and the two directions are independent: each can hold a different word, and all 18 bits, including bit 17, pass unchanged.
- R2: While `le_ab` is 1, `b_o` equals the kept A input combinationally.
- R3: While `le_ab` is 0 and `clk_ab` does not fall, `b_o` holds the stored word. When `le_ab` drops from 1 to 0 with no clock edge, the stored word is the last A input seen while transparent.
- R4: While `le_ab` is 0, a 1-to-0 transition of `clk_ab` loads the current A input into the store. A 0-to-1 transition of `clk_ab` loads nothing.
- R5: `b_oe` is 1 exactly when `oe_ab` is 1 and `pwr_rst` is 0.
- R6: B-to-A follows the R2 to R4 rules using `le_ba` and `clk_ba`, driving `a_o`. `a_oe` is 1 exactly when `oe_ba_n` is 0 and `pwr_rst` is 0.
- R7: When a port's drive flag (`a_drv` or `b_drv`) is 0, the store for that direction sees the last word present while the flag was 1, whatever the data input carries.
- R8: While `pwr_rst` is 1, `a_oe` and `b_oe` are both 0. After `pwr_rst` is released with both latch enables at 0, `a_o` and `b_o` read zero.
- R9: A falling clock edge after a hold overwrites the word kept from transparency. A falling clock edge that coincides with the latch enable falling leaves the output equal to the input word present at that instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwr_rst | input | 1 | Power-up reset: both ports undriven, stores and keepers cleared |
| a_i | input | 18 | Word arriving on port A |
| a_drv | input | 1 | 1 when an outside source is driving port A |
| b_i | input | 18 | Word arriving on port B |
| b_drv | input | 1 | 1 when an outside source is driving port B |
| le_ab | input | 1 | A-to-B latch enable, transparent when 1 |
| clk_ab | input | 1 | A-to-B clock, loads on falling edge |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, transparent when 1 |
| clk_ba | input | 1 | B-to-A clock, loads on falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_o | output | 18 | Word driven onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_o | output | 18 | Word driven onto port B |
| b_oe | output | 1 | Drive enable for port B |

## Verification
The clock and the latch enable of one direction can change in the same instant. The case that matters is the clock falling while the latch enable falls. The bench provokes it by raising the clock, then dropping the clock and the latch enable in one statement with the input word held steady. It judges the result by requiring that the output equals that word, and that the output still equals it after the input moves. This result does not depend on which of the two changes the store sees first. The bench also counts a failure whenever it drives a port that the block is driving at the same time.

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int W = 18
) (
  input  logic         pwr_rst,
  input  logic [W-1:0] a_i,
  input  logic         a_drv,
  input  logic [W-1:0] b_i,
  input  logic         b_drv,
  input  logic         le_ab,
  input  logic         clk_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         clk_ba,
  input  logic         oe_ba_n,
  output logic [W-1:0] a_o,
  output logic         a_oe,
  output logic [W-1:0] b_o,
  output logic         b_oe
);

  logic [W-1:0] a_keep, b_keep, a_ext, b_ext;

  always_latch
    if (pwr_rst) a_keep = '0;
    else if (a_drv) a_keep = a_i;

  always_latch
    if (pwr_rst) b_keep = '0;
    else if (b_drv) b_keep = b_i;

  assign a_ext = a_drv ? a_i : a_keep;
  assign b_ext = b_drv ? b_i : b_keep;

  logic [W-1:0] ab_lat, ab_ff, ba_lat, ba_ff;
  logic         ab_edge, ba_edge;

  always_latch
    if (pwr_rst) ab_lat = '0;
    else if (le_ab) ab_lat = a_ext;

  always_ff @(negedge clk_ab or posedge pwr_rst)
    if (pwr_rst) ab_ff <= '0;
    else if (!le_ab) ab_ff <= a_ext;

  always_ff @(negedge clk_ab or posedge le_ab or posedge pwr_rst)
    if (pwr_rst) ab_edge <= 1'b0;
    else if (le_ab) ab_edge <= 1'b0;
    else ab_edge <= 1'b1;

  always_latch
    if (pwr_rst) ba_lat = '0;
    else if (le_ba) ba_lat = b_ext;

  always_ff @(negedge clk_ba or posedge pwr_rst)
    if (pwr_rst) ba_ff <= '0;
    else if (!le_ba) ba_ff <= b_ext;

  always_ff @(negedge clk_ba or posedge le_ba or posedge pwr_rst)
    if (pwr_rst) ba_edge <= 1'b0;
    else if (le_ba) ba_edge <= 1'b0;
    else ba_edge <= 1'b1;

  assign b_o  = le_ab ? a_ext : (ab_edge ? ab_ff : ab_lat);
  assign a_o  = le_ba ? b_ext : (ba_edge ? ba_ff : ba_lat);
  assign b_oe = oe_ab & ~pwr_rst;
  assign a_oe = ~oe_ba_n & ~pwr_rst;

  a_r2_ab_transparent: assert property (@(negedge clk_ab) disable iff (pwr_rst)
    le_ab |-> b_o == a_ext);
  a_r5_ab_enable: assert property (@(negedge clk_ab) disable iff (pwr_rst)
    b_oe == oe_ab);
  a_r6_ba_transparent: assert property (@(negedge clk_ba) disable iff (pwr_rst)
    le_ba |-> a_o == b_ext);
  a_r6_ba_enable: assert property (@(negedge clk_ba) disable iff (pwr_rst)
    a_oe == !oe_ba_n);
  a_r7_keep_known: assert property (@(negedge clk_ab) disable iff (pwr_rst)
    !$isunknown(a_ext));

endmodule

// File: tb/tb_ubt_xcvr.sv
module tb_ubt_xcvr;
  localparam int W = 18;

  logic tclk = 1'b0;
  always #4 tclk = ~tclk;

  logic         pwr_rst = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         a_drv = 1'b0, b_drv = 1'b0;
  logic         le_ab = 1'b0, clk_ab = 1'b0, oe_ab = 1'b0;
  logic         le_ba = 1'b0, clk_ba = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_o, b_o;
  logic         a_oe, b_oe;

  int n_chk = 0, n_bad = 0, cyc = 0;

  ubt_xcvr #(.W(W)) dut (
    .pwr_rst(pwr_rst), .a_i(a_i), .a_drv(a_drv), .b_i(b_i), .b_drv(b_drv),
    .le_ab(le_ab), .clk_ab(clk_ab), .oe_ab(oe_ab),
    .le_ba(le_ba), .clk_ba(clk_ba), .oe_ba_n(oe_ba_n),
    .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge tclk);
    n_chk++;
    if ((a_drv && a_oe) || (b_drv && b_oe)) begin
      n_bad++;
      $display("FAIL R1 contention: actual a=%b/%b b=%b/%b expected no double drive",
               a_drv, a_oe, b_drv, b_oe);
    end
    @(posedge tclk);
  endtask

  task automatic t_reset();
    oe_ab = 1; oe_ba_n = 0; pwr_rst = 1;
    step();
    chk("R8 b_oe in reset", W'(b_oe), '0);
    chk("R8 a_oe in reset", W'(a_oe), '0);
    pwr_rst = 0; oe_ab = 0; oe_ba_n = 1;
    step();
    chk("R8 b_o cleared", b_o, '0);
    chk("R8 a_o cleared", a_o, '0);
  endtask

  task automatic t_ab_modes();
    logic [W-1:0] v1 = 18'h2A5C3;
    logic [W-1:0] v2 = 18'h1035F;
    oe_ab = 1; oe_ba_n = 1; a_drv = 1; le_ab = 1;
    a_i = 18'h00001; step(); chk("R2 pattern 1", b_o, 18'h00001);
    a_i = 18'h3FFFF; step(); chk("R2 pattern 2", b_o, 18'h3FFFF);
    a_i = v1;        step(); chk("R2 pattern 3", b_o, v1);
    chk("R5 b_oe high", W'(b_oe), W'(1));
    le_ab = 0; step();
    a_i = v2; step();
    chk("R3 hold after LE fall", b_o, v1);
    clk_ab = 1; step();
    chk("R4 rising edge ignored", b_o, v1);
    clk_ab = 0; step();
    chk("R9 falling edge overwrites", b_o, v2);
    a_i = 18'h15555; step();
    chk("R3 hold after capture", b_o, v2);
    clk_ab = 1; step(); clk_ab = 0; step();
    chk("R4 second capture", b_o, 18'h15555);
    oe_ab = 0; step();
    chk("R5 b_oe low", W'(b_oe), '0);
  endtask

  task automatic t_ba_modes();
    oe_ab = 0; a_drv = 0; b_drv = 1; oe_ba_n = 0; le_ba = 1;
    b_i = 18'h0F0F0; step(); chk("R6 transparent", a_o, 18'h0F0F0);
    chk("R6 a_oe with low enable", W'(a_oe), W'(1));
    le_ba = 0; step();
    b_i = 18'h33333; step(); chk("R6 hold", a_o, 18'h0F0F0);
    clk_ba = 1; step(); chk("R6 rising ignored", a_o, 18'h0F0F0);
    clk_ba = 0; step(); chk("R6 falling capture", a_o, 18'h33333);
    oe_ba_n = 1; step(); chk("R6 a_oe off", W'(a_oe), '0);
  endtask

  task automatic t_keeper();
    oe_ba_n = 1; b_drv = 0; oe_ab = 1; a_drv = 1; le_ab = 1;
    a_i = 18'h2B00D; step();
    a_drv = 0; a_i = 18'h01234; step();
    chk("R7 transparent sees kept word", b_o, 18'h2B00D);
    le_ab = 0; step(); clk_ab = 1; step(); clk_ab = 0; step();
    chk("R7 capture sees kept word", b_o, 18'h2B00D);
  endtask

  task automatic t_coincide();
    oe_ab = 1; a_drv = 1; le_ab = 1; a_i = 18'h2C3A7; clk_ab = 1; step();
    le_ab = 0; clk_ab = 0; step();
    chk("R9 coincident edge and LE fall", b_o, 18'h2C3A7);
    a_i = 18'h00F00; step();
    chk("R9 held after coincident edge", b_o, 18'h2C3A7);
    le_ab = 1; clk_ab = 1; step(); clk_ab = 0; step();
    chk("R9 falling edge while transparent", b_o, 18'h00F00);
    le_ab = 0; step();
  endtask

  task automatic t_indep();
    oe_ab = 0; oe_ba_n = 1;
    a_drv = 1; b_drv = 1; a_i = 18'h3FFFF; b_i = 18'h20001;
    le_ab = 1; le_ba = 1; step();
    le_ab = 0; le_ba = 0; step();
    a_drv = 0; b_drv = 0; a_i = '0; b_i = '0; step();
    oe_ab = 1; oe_ba_n = 0; step();
    chk("R1 A-to-B word", b_o, 18'h3FFFF);
    chk("R1 B-to-A word", a_o, 18'h20001);
    pwr_rst = 1; step();
    chk("R8 mid-run b_oe", W'(b_oe), '0);
    chk("R8 mid-run a_oe", W'(a_oe), '0);
    pwr_rst = 0; step();
    chk("R8 b_o zero after release", b_o, '0);
    chk("R8 a_o zero after release", a_o, '0);
    oe_ab = 0; oe_ba_n = 1; step();
  endtask

  always @(posedge tclk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(posedge tclk);
    t_reset();
    t_ab_modes();
    t_ba_modes();
    t_keeper();
    t_coincide();
    t_indep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule